// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. It holds the accumulator and a five-bit flag set: carry, zero, sign, parity and auxiliary (half) carry. Each time the execute strobe is high on a rising clock edge, it applies one operation to the accumulator. The operation is chosen by a 5-bit operation code. The second operand comes in on an 8-bit port, which the surrounding datapath feeds from a register, from memory or from an immediate field.

The operations are:
- add and subtract, each with and without the carry/borrow flag;
- compare;
- the three bitwise logic operations;
- accumulator complement;
- four rotates;
- carry set and carry complement;
- increment and decrement;
- decimal adjust after a packed-BCD addition.

Each operation updates only the flags it is defined to touch. All other state is held.

After reset the accumulator is zero. A value is loaded by adding it to that zero.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, acc is 0x00 and cy, zf, sf, pf and acf are all 0.
- R2: Timing and encoding. A result appears on the outputs one clock edge after the edge at which exec is high. When exec is low, or op is 18 to 31, all outputs hold their values. The op codes are: 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 CMP, 5 AND, 6 OR, 7 XOR, 8 CMA, 9 RLC, 10 RRC, 11 RAL, 12 RAR, 13 STC, 14 CMC, 15 INC, 16 DEC, 17 DAA.
- R3: Every operation that updates zero, sign and parity sets them from its 8-bit result, as follows:
  - zf is 1 when the result is 0x00;
  - sf equals result bit 7;
  - pf is 1 when the result holds an even number of ones.
  The operations that update these flags are ADD, ADC, SUB, SBB, CMP, AND, OR, XOR, INC, DEC and DAA.
- R4: ADD and ADC write the 8-bit sum of acc and operand into acc. ADC also adds the incoming cy; ADD ignores it. cy becomes the carry out of bit 7. acf becomes the carry out of bit 3.
- R5: SUB and SBB write acc minus operand into acc. SBB also subtracts the incoming cy. cy becomes the borrow: it is set when the operand, plus the borrow for SBB, exceeds acc as unsigned numbers. acf becomes the borrow out of the low nibble.
- R6: CMP sets cy, acf, zf, sf and pf exactly as SUB would, and leaves acc unchanged.
- R7: AND, OR and XOR write the bitwise result into acc and clear both cy and acf.
- R8: CMA writes the bitwise inverse of acc into acc and changes no flag.
- R9: RLC rotates acc left by one, so bit 7 goes to bit 0 and also into cy. RRC rotates acc right by one, so bit 0 goes to bit 7 and also into cy.
- R10: RAL shifts acc left, putting bit 7 into cy and the old cy into bit 0. RAR shifts acc right, putting bit 0 into cy and the old cy into bit 7. No rotate changes zf, sf, pf or acf.
- R11: STC sets cy to 1. CMC inverts cy. Neither changes acc or any other flag.
- R12: INC and DEC add or subtract one, and cy holds its value. For INC, acf is set when the old low nibble was 0xF. For DEC, acf is set when the old low nibble was 0x0.
- R13: DAA works in two steps:
  - First, it adds 6 when the low nibble is above 9 or acf is set. This gives a 9-bit intermediate value t.
  - Second, it adds 0x60 to t[7:0] when any of these holds: t[7:4] is above 9, cy is set, or t bit 8 is set.
  The new cy is the old cy OR either step's carry out of bit 7. acf is the carry out of bit 3 produced by the first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exec | input | 1 | Apply op on this edge |
| op | input | 5 | Operation code (see R2) |
| operand | input | 8 | Second operand |
| acc | output | 8 | Accumulator |
| cy | output | 1 | Carry / borrow flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| pf | output | 1 | Even-parity flag |
| acf | output | 1 | Auxiliary (bit 3) carry flag |

## Verification
Every result, the accumulator and all five flags alike, is due exactly one rising edge after the edge that sees exec high. This holds for every op code, and CMP, CMA and the rotates are no exception even though they leave some state alone. The bench changes its inputs on a falling edge and compares all six outputs on the next falling edge, half a cycle after that rising edge. Its own reference model advances at the same point. Idle cycles and unused op codes are checked the same way, against an unchanged expected state.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [4:0] op,
  input  logic [7:0] operand,
  output logic [7:0] acc,
  output logic       cy,
  output logic       zf,
  output logic       sf,
  output logic       pf,
  output logic       acf
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3;
  localparam logic [4:0] OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7;
  localparam logic [4:0] OP_CMA = 5'd8,  OP_RLC = 5'd9,  OP_RRC = 5'd10, OP_RAL = 5'd11;
  localparam logic [4:0] OP_RAR = 5'd12, OP_STC = 5'd13, OP_CMC = 5'd14, OP_INC = 5'd15;
  localparam logic [4:0] OP_DEC = 5'd16, OP_DAA = 5'd17;

  logic       cin, bin;
  logic [8:0] sum9, dif9, t1, t2;
  logic [4:0] sumlo, diflo, daalo;
  logic       lo_fix, hi_fix;

  assign cin   = (op == OP_ADC) & cy;
  assign bin   = (op == OP_SBB) & cy;
  assign sum9  = {1'b0, acc} + {1'b0, operand} + {8'd0, cin};
  assign sumlo = {1'b0, acc[3:0]} + {1'b0, operand[3:0]} + {4'd0, cin};
  assign dif9  = {1'b0, acc} - {1'b0, operand} - {8'd0, bin};
  assign diflo = {1'b0, acc[3:0]} - {1'b0, operand[3:0]} - {4'd0, bin};

  assign lo_fix = (acc[3:0] > 4'd9) | acf;
  assign daalo  = {1'b0, acc[3:0]} + (lo_fix ? 5'd6 : 5'd0);
  assign t1     = {1'b0, acc} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix = (t1[7:4] > 4'd9) | cy | t1[8];
  assign t2     = {1'b0, t1[7:0]} + (hi_fix ? 9'h060 : 9'h000);

  logic [7:0] n_acc, fres;
  logic       n_cy, n_ac, upd;

  always_comb begin
    n_acc = acc;
    n_cy  = cy;
    n_ac  = acf;
    fres  = acc;
    upd   = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        n_acc = sum9[7:0]; n_cy = sum9[8]; n_ac = sumlo[4]; fres = sum9[7:0]; upd = 1'b1;
      end
      OP_SUB, OP_SBB: begin
        n_acc = dif9[7:0]; n_cy = dif9[8]; n_ac = diflo[4]; fres = dif9[7:0]; upd = 1'b1;
      end
      OP_CMP: begin
        n_cy = dif9[8]; n_ac = diflo[4]; fres = dif9[7:0]; upd = 1'b1;
      end
      OP_AND: begin n_acc = acc & operand; n_cy = 1'b0; n_ac = 1'b0; fres = acc & operand; upd = 1'b1; end
      OP_OR:  begin n_acc = acc | operand; n_cy = 1'b0; n_ac = 1'b0; fres = acc | operand; upd = 1'b1; end
      OP_XOR: begin n_acc = acc ^ operand; n_cy = 1'b0; n_ac = 1'b0; fres = acc ^ operand; upd = 1'b1; end
      OP_CMA: n_acc = ~acc;
      OP_RLC: begin n_acc = {acc[6:0], acc[7]}; n_cy = acc[7]; end
      OP_RRC: begin n_acc = {acc[0], acc[7:1]}; n_cy = acc[0]; end
      OP_RAL: begin n_acc = {acc[6:0], cy};     n_cy = acc[7]; end
      OP_RAR: begin n_acc = {cy, acc[7:1]};     n_cy = acc[0]; end
      OP_STC: n_cy = 1'b1;
      OP_CMC: n_cy = ~cy;
      OP_INC: begin
        n_acc = acc + 8'd1; n_ac = (acc[3:0] == 4'hF); fres = acc + 8'd1; upd = 1'b1;
      end
      OP_DEC: begin
        n_acc = acc - 8'd1; n_ac = (acc[3:0] == 4'h0); fres = acc - 8'd1; upd = 1'b1;
      end
      OP_DAA: begin
        n_acc = t2[7:0]; n_cy = cy | t1[8] | t2[8]; n_ac = daalo[4]; fres = t2[7:0]; upd = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= 8'h00; cy <= 1'b0; zf <= 1'b0; sf <= 1'b0; pf <= 1'b0; acf <= 1'b0;
    end else if (exec) begin
      acc <= n_acc;
      cy  <= n_cy;
      acf <= n_ac;
      if (upd) begin
        zf <= (fres == 8'h00);
        sf <= fres[7];
        pf <= ~^fres;
      end
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable({acc, cy, zf, sf, pf, acf}));
  // R6
  cmp_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_CMP) |=> $stable(acc));
  // R7
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> (!cy && !acf));
  // R8
  cma_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_CMA) |=> ($stable({cy, zf, sf, pf, acf}) && acc == ~$past(acc)));
  // R10
  rot_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op >= OP_RLC && op <= OP_RAR) |=> $stable({zf, sf, pf, acf}));
  // R11
  stc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_STC) |=> cy);
  // R11
  cmc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_CMC) |=> (cy != $past(cy)));
  // R12
  incdec_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == OP_INC || op == OP_DEC)) |=> $stable(cy));
  // R13
  daa_cy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_DAA && cy) |=> cy);
  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_AND && operand == 8'h00) |=> (zf && !sf && pf));
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       exec;
  logic [4:0] op;
  logic [7:0] operand;
  logic [7:0] acc;
  logic       cy, zf, sf, pf, acf;

  acc_alu dut (.clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .operand(operand),
               .acc(acc), .cy(cy), .zf(zf), .sf(sf), .pf(pf), .acf(acf));

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_acc;
  logic       m_cy, m_z, m_s, m_p, m_ac;

  function automatic string tag_of(input logic e, input logic [4:0] o);
    if (!e || o > 5'd17) return "R2 hold";
    case (o)
      5'd0, 5'd1:  return "R4 add";
      5'd2, 5'd3:  return "R5 sub";
      5'd4:        return "R6 cmp";
      5'd5, 5'd6, 5'd7: return "R7 logic";
      5'd8:        return "R8 cma";
      5'd9, 5'd10: return "R9 rotate";
      5'd11, 5'd12: return "R10 rotate-carry";
      5'd13, 5'd14: return "R11 carry-op";
      5'd15, 5'd16: return "R12 inc-dec";
      default:     return "R13 daa";
    endcase
  endfunction

  // R3: zero/sign/parity from an 8-bit result
  task automatic set_zsp(input logic [7:0] r);
    m_z = (r == 8'h00);
    m_s = r[7];
    m_p = ((($countones(r)) % 2) == 0);
  endtask

  task automatic model(input logic [4:0] o, input logic [7:0] d);
    int a, b, c, r, lo;
    a = m_acc; b = d;
    case (o)
      5'd0, 5'd1: begin
        c = (o == 5'd1 && m_cy) ? 1 : 0;
        r = a + b + c;
        m_ac = ((a % 16) + (b % 16) + c) > 15;
        m_cy = r > 255; m_acc = r[7:0]; set_zsp(r[7:0]);
      end
      5'd2, 5'd3, 5'd4: begin
        c = (o == 5'd3 && m_cy) ? 1 : 0;
        r = a - b - c;
        m_ac = ((b % 16) + c) > (a % 16);
        m_cy = (b + c) > a;
        if (o != 5'd4) m_acc = r[7:0];
        set_zsp(r[7:0]);
      end
      5'd5: begin m_acc = m_acc & d; m_cy = 0; m_ac = 0; set_zsp(m_acc); end
      5'd6: begin m_acc = m_acc | d; m_cy = 0; m_ac = 0; set_zsp(m_acc); end
      5'd7: begin m_acc = m_acc ^ d; m_cy = 0; m_ac = 0; set_zsp(m_acc); end
      5'd8: m_acc = ~m_acc;
      5'd9:  begin m_cy = m_acc[7]; m_acc = (m_acc << 1) | (m_acc >> 7); end
      5'd10: begin m_cy = m_acc[0]; m_acc = (m_acc >> 1) | (m_acc << 7); end
      5'd11: begin r = {m_acc, m_cy}; m_cy = m_acc[7]; m_acc = r[7:0]; end
      5'd12: begin r = {m_cy, m_acc}; m_cy = m_acc[0]; m_acc = r[8:1]; end
      5'd13: m_cy = 1;
      5'd14: m_cy = ~m_cy;
      5'd15: begin m_ac = (a % 16) == 15; m_acc = m_acc + 8'd1; set_zsp(m_acc); end
      5'd16: begin m_ac = (a % 16) == 0;  m_acc = m_acc - 8'd1; set_zsp(m_acc); end
      5'd17: begin
        lo = ((a % 16) > 9 || m_ac) ? 6 : 0;
        m_ac = ((a % 16) + lo) > 15;
        r = a + lo;
        c = (((r % 256) / 16) > 9 || m_cy || r > 255) ? 96 : 0;
        if (r > 255 || ((r % 256) + c) > 255) m_cy = 1;
        r = (r % 256) + c;
        m_acc = r[7:0]; set_zsp(m_acc);
      end
      default: ;
    endcase
  endtask

  task automatic compare(input string tag);
    logic [12:0] got, exp;
    got = {acc, cy, zf, sf, pf, acf};
    exp = {m_acc, m_cy, m_z, m_s, m_p, m_ac};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: acc/cy/z/s/p/ac got %h %b expected %h %b", tag,
               got[12:5], got[4:0], exp[12:5], exp[4:0]);
    end
  endtask

  // call at a falling edge
  task automatic step(input logic e, input logic [4:0] o, input logic [7:0] d);
    exec = e; op = o; operand = d;
    @(negedge clk);
    if (e) model(o, d);
    compare(tag_of(e, o));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; exec = 1'b1; op = 5'd0; operand = 8'h5A;
    repeat (3) @(negedge clk);
    m_acc = 0; m_cy = 0; m_z = 0; m_s = 0; m_p = 0; m_ac = 0;
    compare("R1 reset");
    rst_n = 1'b1;
    exec = 1'b0;
    @(negedge clk);

    // directed corners
    step(1, 5'd0, 8'hFF);  // R4 load
    step(1, 5'd0, 8'h01);  // R4 wrap to zero, carry and aux
    step(1, 5'd1, 8'h0F);  // R4 adc with carry in
    step(1, 5'd0, 8'h00);  // R4 add ignores carry
    step(1, 5'd2, 8'h20);  // R5 borrow
    step(1, 5'd3, 8'h01);  // R5 sbb with borrow
    step(1, 5'd4, 8'hEE);  // R6 compare equal-ish
    step(1, 5'd4, 8'h00);  // R6
    step(1, 5'd5, 8'h00);  // R7 zero result
    step(1, 5'd6, 8'h81);  // R7
    step(1, 5'd8, 8'h00);  // R8
    step(1, 5'd13, 8'h00); // R11 stc
    step(1, 5'd11, 8'h00); // R10 ral
    step(1, 5'd12, 8'h00); // R10 rar
    step(1, 5'd9, 8'h00);  // R9 rlc
    step(1, 5'd10, 8'h00); // R9 rrc
    step(1, 5'd14, 8'h00); // R11 cmc
    step(1, 5'd7, 8'hFF);  // R7 xor
    step(1, 5'd16, 8'h00); // R12 dec
    step(1, 5'd15, 8'h00); // R12 inc
    step(1, 5'd5, 8'h00);  // clear
    step(1, 5'd0, 8'h38);  // BCD 38 + 45
    step(1, 5'd0, 8'h45);
    step(1, 5'd17, 8'h00); // R13 -> 83
    step(1, 5'd0, 8'h19);  // 83 + 19 + 0 -> 9C
    step(1, 5'd17, 8'h00); // R13 -> 02 with carry
    step(1, 5'd5, 8'h00);
    step(1, 5'd0, 8'hFF);
    step(1, 5'd17, 8'h00); // R13 overflow of low step
    step(1, 5'd20, 8'h12); // R2 unused code
    step(0, 5'd0, 8'h33);  // R2 idle

    for (int i = 0; i < 4000; i++) begin
      logic e;
      logic [4:0] o;
      e = ($urandom % 8) != 0;
      o = 5'($urandom % 20);
      step(e, o, 8'($urandom));
    end

    exec = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule